// File: doc/BRIEF.md
# Mode-Banked Register File with Status Control

This block is the architectural register storage of a 32-bit processor core that runs in several privilege modes. Software always addresses sixteen logical registers by a 4-bit number, but the physical register actually touched depends on the current mode. The fast-interrupt mode has private copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have private copies of registers 13 and 14 only. The user and system modes share one set. In total there are 31 general physical registers, one current status word and five saved status words, which gives 37 words of storage.

The block has two combinational read ports and one write port. It also has three ways to change the status word. The first is an exception-entry request. It saves the current status into the target mode's saved status word, switches mode and stores a return address in the target mode's register 14. The second is a return request, which reloads the status word from the active mode's saved copy. The third is a direct status write, which is limited to the condition flags when the core is in user mode.

The current mode is the state of the block's controller. The states are USR (10000), FIQ (10001), IRQ (10010), SVC (10011), ABT (10111), UND (11011) and SYS (11111). There are three transitions:
- ENTER moves from any state to one of FIQ, IRQ, SVC, ABT or UND.
- RESTORE moves from an exception state to the mode held in that state's saved status word.
- PROGRAM is a direct write that carries any privileged state to any legal mode.

Top module: `moded_regfile`

## Requirements
- R1: Reset (synchronous, active-low) selects supervisor mode. The status word becomes 0x000000D3: flags clear, I (bit 7) = 1, F (bit 6) = 1, T (bit 5) = 0, mode 10011. Every general physical register is cleared.
- R2: A write through the write port to logical register n is returned on both read ports from the next cycle on. Logical registers 0 to 7 and 15 refer to the same storage in every mode.
- R3: Banking follows these rules:
  - Fast-interrupt mode (10001) has private registers 8 to 14.
  - Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private registers 13 and 14.
  - User (10000) and system (11111) modes use the same registers.
- R4: When a read port and the write port address the same physical register in the same cycle, the read returns the value being written.
- R5: An exception request whose target mode is fiq, irq, svc, abt or und has these effects on the next cycle:
  - The target's saved status word holds the previous status word.
  - The mode is the target mode, I = 1 and T = 0.
  - F = 1 for a fast-interrupt target; otherwise F is unchanged. The flags are kept.
  - The target's register 14 holds the supplied return address.
  
  A request with any other target code is ignored.
- R6: A return request in an exception mode loads the status word from that mode's saved status word, which rebanks the previous mode's registers. In user or system mode a return request is ignored.
- R7: A direct status write in a privileged mode replaces the flags (bits 31:28) and bits 7:5. It replaces the mode field only when bits 4:0 hold one of the seven legal codes; otherwise the mode is kept. It never alters any saved status word. All other status bits read as zero.
- R8: A direct status write in user mode changes only bits 31:28.
- R9: The saved-status output shows the active mode's saved status word, and shows zero in user and system modes.
- R10: When requests coincide, exception entry takes precedence over return, and return takes precedence over a direct status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_b_idx | input | 4 | Logical register number, read port B |
| wr_en | input | 1 | Write-port enable |
| wr_idx | input | 4 | Logical register number, write port |
| wr_data | input | 32 | Write-port data |
| exc_req | input | 1 | Exception-entry request |
| exc_mode | input | 5 | Target mode code for exception entry |
| exc_ret_addr | input | 32 | Return address stored in the target's register 14 |
| ret_req | input | 1 | Return-from-exception request |
| sw_en | input | 1 | Direct status write enable |
| sw_data | input | 32 | Direct status write value |
| rd_a_data | output | 32 | Read port A data |
| rd_b_data | output | 32 | Read port B data |
| cur_status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status word of the active mode |

## Verification
The hardest case to reach is a return that has to unwind two nested exceptions and land in the right bank at each step. The stimulus builds that path in order:
- A privileged direct write moves the core into system mode with non-zero flags.
- Interrupt entry follows, and then fast-interrupt entry from inside interrupt mode.
- A back-to-back pair of returns then walks down the chain.
- At each level the bench reads registers 8, 13 and 14 and compares them with the values it wrote earlier into each bank.

Two further cases are covered by directed cycles after the vector table. One raises exception, return and status-write requests together. The other makes a read and a write to the same banked register in the same cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    localparam int NUM_LOGICAL  = 16;
    localparam int NUM_GPR_PHYS = 31;
    localparam int NUM_SAVED    = 5;
    localparam int PHYS_W       = $clog2(NUM_GPR_PHYS);
    localparam int SLOT_W       = $clog2(NUM_SAVED);

    function automatic logic mode_legal(input logic [4:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: mode_legal = 1'b1;
            default:                      mode_legal = 1'b0;
        endcase
    endfunction

    function automatic logic mode_has_saved(input logic [4:0] m);
        case (m)
            MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: mode_has_saved = 1'b1;
            default:                                          mode_has_saved = 1'b0;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] saved_slot(input logic [4:0] m);
        case (m)
            MODE_FIQ: saved_slot = SLOT_W'(0);
            MODE_IRQ: saved_slot = SLOT_W'(1);
            MODE_SVC: saved_slot = SLOT_W'(2);
            MODE_ABT: saved_slot = SLOT_W'(3);
            default:  saved_slot = SLOT_W'(4);
        endcase
    endfunction

    // Physical layout: 0..15 shared, 16..22 fiq r8..r14,
    // 23/24 irq, 25/26 svc, 27/28 abt, 29/30 und (r13, r14).
    function automatic logic [PHYS_W-1:0] phys_map(input logic [4:0] m, input logic [3:0] r);
        logic [PHYS_W-1:0] base;
        logic              hi;
        phys_map = {1'b0, r};
        hi       = (r == 4'd14);
        base     = '0;
        if (m == MODE_FIQ && r >= 4'd8 && r <= 4'd14) begin
            phys_map = PHYS_W'(16) + {1'b0, r} - PHYS_W'(8);
        end else if (r == 4'd13 || r == 4'd14) begin
            case (m)
                MODE_IRQ: base = PHYS_W'(23);
                MODE_SVC: base = PHYS_W'(25);
                MODE_ABT: base = PHYS_W'(27);
                MODE_UND: base = PHYS_W'(29);
                default:  base = {1'b0, r} - PHYS_W'(hi);
            endcase
            phys_map = base + PHYS_W'(hi);
        end
    endfunction

endpackage

// File: rtl/rf_status_ctrl.sv
module rf_status_ctrl
    import rf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_req,
    input  logic [4:0]      exc_mode,
    input  logic            ret_req,
    input  logic            sw_en,
    input  logic [XLEN-1:0] sw_data,
    output logic [4:0]      mode,
    output logic            exc_take,
    output logic [XLEN-1:0] cpsr,
    output logic [XLEN-1:0] spsr_view
);

    localparam int PAD_W = XLEN - 12;

    mode_e           mode_q, mode_n;
    logic [3:0]      flags_q, flags_n;
    logic            ibit_q, ibit_n, fbit_q, fbit_n, tbit_q, tbit_n;
    logic [XLEN-1:0] saved_q [NUM_SAVED];
    logic            ret_take, sw_take;
    logic [XLEN-1:0] ret_src;

    assign exc_take = exc_req && mode_has_saved(exc_mode);
    assign ret_take = !exc_take && ret_req && mode_has_saved(mode_q);
    assign sw_take  = !exc_take && !ret_take && sw_en;
    assign ret_src  = saved_q[saved_slot(mode_q)];

    // next-state logic: ENTER, RESTORE, PROGRAM
    always_comb begin
        mode_n  = mode_q;
        flags_n = flags_q;
        ibit_n  = ibit_q;
        fbit_n  = fbit_q;
        tbit_n  = tbit_q;
        if (exc_take) begin
            mode_n = mode_e'(exc_mode);
            ibit_n = 1'b1;
            fbit_n = fbit_q | (exc_mode == MODE_FIQ);
            tbit_n = 1'b0;
        end else if (ret_take) begin
            flags_n = ret_src[XLEN-1 -: 4];
            ibit_n  = ret_src[7];
            fbit_n  = ret_src[6];
            tbit_n  = ret_src[5];
            if (mode_legal(ret_src[4:0])) mode_n = mode_e'(ret_src[4:0]);
        end else if (sw_take) begin
            flags_n = sw_data[XLEN-1 -: 4];
            unique case (mode_q)
                MODE_USR: ;
                MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND, MODE_SYS: begin
                    ibit_n = sw_data[7];
                    fbit_n = sw_data[6];
                    tbit_n = sw_data[5];
                    if (mode_legal(sw_data[4:0])) mode_n = mode_e'(sw_data[4:0]);
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_SVC;
            flags_q <= '0;
            ibit_q  <= 1'b1;
            fbit_q  <= 1'b1;
            tbit_q  <= 1'b0;
            for (int k = 0; k < NUM_SAVED; k++) saved_q[k] <= '0;
        end else begin
            mode_q  <= mode_n;
            flags_q <= flags_n;
            ibit_q  <= ibit_n;
            fbit_q  <= fbit_n;
            tbit_q  <= tbit_n;
            if (exc_take) saved_q[saved_slot(exc_mode)] <= cpsr;
        end
    end

    // outputs
    always_comb begin
        cpsr = {flags_q, {PAD_W{1'b0}}, ibit_q, fbit_q, tbit_q, mode_q};
        mode = mode_q;
        unique case (mode_q)
            MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND:           spsr_view = saved_q[saved_slot(mode_q)];
            MODE_USR, MODE_SYS:           spsr_view = '0;
            default:                      spsr_view = '0;
        endcase
    end

    p_exc_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> spsr_view == $past(cpsr));

    p_exc_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && mode_has_saved(exc_mode)) |=> (cpsr[4:0] == $past(exc_mode)) && cpsr[7] && !cpsr[5]);

    p_ret_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !exc_req && mode_has_saved(cpsr[4:0])) |=> cpsr == $past(spsr_view));

    p_user_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !exc_req && !ret_req && cpsr[4:0] == MODE_USR) |=> cpsr[7:0] == $past(cpsr[7:0]));

    p_mode_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(cpsr[4:0]));

    p_user_no_saved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr[4:0] == MODE_USR || cpsr[4:0] == MODE_SYS) |-> spsr_view == '0);

endmodule

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank
    import rf_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NRD  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [4:0]               mode,
    input  logic [NRD-1:0][3:0]      rd_idx,
    output logic [NRD-1:0][XLEN-1:0] rd_data,
    input  logic                     wr_en,
    input  logic [3:0]               wr_idx,
    input  logic [XLEN-1:0]          wr_data,
    input  logic                     exc_wr_en,
    input  logic [4:0]               exc_wr_mode,
    input  logic [XLEN-1:0]          exc_wr_data
);

    localparam int DEPTH = 1 << PHYS_W;

    logic [XLEN-1:0]   regs [DEPTH];
    logic [PHYS_W-1:0] wr_phys, exc_phys;

    assign wr_phys  = phys_map(mode, wr_idx);
    assign exc_phys = phys_map(exc_wr_mode, 4'd14);

    // exception link write lands after the port write, so it wins on a clash
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) regs[k] <= '0;
        end else begin
            if (wr_en)     regs[wr_phys]  <= wr_data;
            if (exc_wr_en) regs[exc_phys] <= exc_wr_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [PHYS_W-1:0] rd_phys;
        assign rd_phys = phys_map(mode, rd_idx[g]);
        always_comb begin
            if (wr_en && wr_phys == rd_phys) rd_data[g] = wr_data;
            else                             rd_data[g] = regs[rd_phys];
        end
    end

    p_bank_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_phys) < NUM_GPR_PHYS);

endmodule

// File: rtl/moded_regfile.sv
module moded_regfile
    import rf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      rd_a_idx,
    input  logic [3:0]      rd_b_idx,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            exc_req,
    input  logic [4:0]      exc_mode,
    input  logic [XLEN-1:0] exc_ret_addr,
    input  logic            ret_req,
    input  logic            sw_en,
    input  logic [XLEN-1:0] sw_data,
    output logic [XLEN-1:0] rd_a_data,
    output logic [XLEN-1:0] rd_b_data,
    output logic [XLEN-1:0] cur_status,
    output logic [XLEN-1:0] saved_status
);

    localparam int NRD = 2;

    logic [4:0]               cur_mode;
    logic                     exc_take;
    logic [NRD-1:0][3:0]      rd_idx;
    logic [NRD-1:0][XLEN-1:0] rd_data;

    assign rd_idx    = {rd_b_idx, rd_a_idx};
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    rf_status_ctrl #(.XLEN(XLEN)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_req   (exc_req),
        .exc_mode  (exc_mode),
        .ret_req   (ret_req),
        .sw_en     (sw_en),
        .sw_data   (sw_data),
        .mode      (cur_mode),
        .exc_take  (exc_take),
        .cpsr      (cur_status),
        .spsr_view (saved_status)
    );

    rf_gpr_bank #(.XLEN(XLEN), .NRD(NRD)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (cur_mode),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .exc_wr_en   (exc_take),
        .exc_wr_mode (exc_mode),
        .exc_wr_data (exc_ret_addr)
    );

    p_reset_svc_r1: assert property (@(posedge clk)
        !rst_n |=> cur_status == 32'h0000_00D3);

endmodule

// File: tb/moded_regfile_tb.sv
module moded_regfile_tb;

    localparam int OP_WR = 0, OP_RD = 1, OP_EXC = 2, OP_RET = 3,
                   OP_SW = 4, OP_CPSR = 5, OP_SPSR = 6;
    localparam int NV = 63;

    // {op[2:0], arg[4:0], data[31:0], expect[31:0], req[3:0]}
    localparam logic [75:0] VEC [NV] = '{
        {3'd5, 5'd0,  32'h0,        32'h0000_00D3, 4'd1},  // R1
        {3'd0, 5'd1,  32'hA1,       32'h0,         4'd2},
        {3'd0, 5'd8,  32'hB8,       32'h0,         4'd2},
        {3'd0, 5'd13, 32'hC13,      32'h0,         4'd3},
        {3'd0, 5'd14, 32'hC14,      32'h0,         4'd3},
        {3'd1, 5'd1,  32'h0,        32'hA1,        4'd2},  // R2
        {3'd1, 5'd13, 32'h0,        32'hC13,       4'd3},  // R3
        {3'd4, 5'd0,  32'hA000_001F,32'h0,         4'd7},
        {3'd5, 5'd0,  32'h0,        32'hA000_001F, 4'd7},  // R7
        {3'd6, 5'd0,  32'h0,        32'h0,         4'd9},  // R9
        {3'd1, 5'd13, 32'h0,        32'h0,         4'd3},
        {3'd1, 5'd8,  32'h0,        32'hB8,        4'd3},
        {3'd1, 5'd14, 32'h0,        32'h0,         4'd3},
        {3'd0, 5'd13, 32'hD13,      32'h0,         4'd3},
        {3'd2, 5'd18, 32'h100,      32'h0,         4'd5},  // enter irq
        {3'd5, 5'd0,  32'h0,        32'hA000_0092, 4'd5},  // R5
        {3'd6, 5'd0,  32'h0,        32'hA000_001F, 4'd5},
        {3'd1, 5'd14, 32'h0,        32'h100,       4'd5},
        {3'd1, 5'd13, 32'h0,        32'h0,         4'd3},
        {3'd2, 5'd17, 32'h200,      32'h0,         4'd5},  // enter fiq
        {3'd5, 5'd0,  32'h0,        32'hA000_00D1, 4'd5},
        {3'd6, 5'd0,  32'h0,        32'hA000_0092, 4'd5},
        {3'd1, 5'd8,  32'h0,        32'h0,         4'd3},
        {3'd0, 5'd8,  32'hF8,       32'h0,         4'd3},
        {3'd1, 5'd8,  32'h0,        32'hF8,        4'd3},
        {3'd1, 5'd14, 32'h0,        32'h200,       4'd5},
        {3'd2, 5'd20, 32'h300,      32'h0,         4'd5},  // illegal target
        {3'd5, 5'd0,  32'h0,        32'hA000_00D1, 4'd5},
        {3'd1, 5'd14, 32'h0,        32'h200,       4'd5},
        {3'd3, 5'd0,  32'h0,        32'h0,         4'd6},
        {3'd5, 5'd0,  32'h0,        32'hA000_0092, 4'd6},  // R6
        {3'd1, 5'd8,  32'h0,        32'hB8,        4'd6},
        {3'd1, 5'd14, 32'h0,        32'h100,       4'd6},
        {3'd3, 5'd0,  32'h0,        32'h0,         4'd6},
        {3'd5, 5'd0,  32'h0,        32'hA000_001F, 4'd6},
        {3'd1, 5'd13, 32'h0,        32'hD13,       4'd6},
        {3'd3, 5'd0,  32'h0,        32'h0,         4'd6},
        {3'd5, 5'd0,  32'h0,        32'hA000_001F, 4'd6},
        {3'd4, 5'd0,  32'h4000_00F5,32'h0,         4'd7},
        {3'd5, 5'd0,  32'h0,        32'h4000_00FF, 4'd7},
        {3'd4, 5'd0,  32'h0000_0010,32'h0,         4'd7},
        {3'd5, 5'd0,  32'h0,        32'h0000_0010, 4'd7},
        {3'd6, 5'd0,  32'h0,        32'h0,         4'd9},
        {3'd4, 5'd0,  32'hF000_00D3,32'h0,         4'd8},
        {3'd5, 5'd0,  32'h0,        32'hF000_0010, 4'd8},  // R8
        {3'd3, 5'd0,  32'h0,        32'h0,         4'd6},
        {3'd5, 5'd0,  32'h0,        32'hF000_0010, 4'd6},
        {3'd2, 5'd19, 32'h400,      32'h0,         4'd5},  // enter svc
        {3'd5, 5'd0,  32'h0,        32'hF000_0093, 4'd5},
        {3'd6, 5'd0,  32'h0,        32'hF000_0010, 4'd5},
        {3'd1, 5'd13, 32'h0,        32'hC13,       4'd3},
        {3'd1, 5'd14, 32'h0,        32'h400,       4'd5},
        {3'd4, 5'd0,  32'h0000_0093,32'h0,         4'd7},
        {3'd5, 5'd0,  32'h0,        32'h0000_0093, 4'd7},
        {3'd6, 5'd0,  32'h0,        32'hF000_0010, 4'd7},
        {3'd4, 5'd0,  32'h0000_0097,32'h0,         4'd3},  // to abt
        {3'd1, 5'd13, 32'h0,        32'h0,         4'd3},
        {3'd0, 5'd13, 32'hAB,       32'h0,         4'd3},
        {3'd4, 5'd0,  32'h0000_009B,32'h0,         4'd3},  // to und
        {3'd1, 5'd13, 32'h0,        32'h0,         4'd3},
        {3'd4, 5'd0,  32'h0000_0093,32'h0,         4'd3},  // back to svc
        {3'd1, 5'd13, 32'h0,        32'hC13,       4'd3},
        {3'd1, 5'd1,  32'h0,        32'hA1,        4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic        wr_en, exc_req, ret_req, sw_en;
    logic [4:0]  exc_mode;
    logic [31:0] wr_data, exc_ret_addr, sw_data;
    logic [31:0] rd_a_data, rd_b_data, cur_status, saved_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    moded_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .exc_req(exc_req), .exc_mode(exc_mode), .exc_ret_addr(exc_ret_addr),
        .ret_req(ret_req), .sw_en(sw_en), .sw_data(sw_data),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .cur_status(cur_status), .saved_status(saved_status)
    );

    task automatic idle();
        wr_en = 0; exc_req = 0; ret_req = 0; sw_en = 0;
        wr_idx = 0; wr_data = 0; exc_mode = 0; exc_ret_addr = 0; sw_data = 0;
        rd_a_idx = 0; rd_b_idx = 0;
    endtask

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual %08h expected %08h", 32'h0, 32'h1);
            summary();
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [4:0]  arg;
            logic [31:0] dat, exp;
            int          req;
            op  = VEC[i][75:73];
            arg = VEC[i][72:68];
            dat = VEC[i][67:36];
            exp = VEC[i][35:4];
            req = int'(VEC[i][3:0]);
            @(negedge clk);
            idle();
            case (int'(op))
                OP_WR:  begin wr_en = 1; wr_idx = arg[3:0]; wr_data = dat; end
                OP_EXC: begin exc_req = 1; exc_mode = arg; exc_ret_addr = dat; end
                OP_RET: ret_req = 1;
                OP_SW:  begin sw_en = 1; sw_data = dat; end
                OP_RD:  begin rd_a_idx = arg[3:0]; rd_b_idx = arg[3:0]; end
                default: ;
            endcase
            #2;
            case (int'(op))
                OP_RD: begin
                    check(req, "read port A", rd_a_data, exp);
                    check(req, "read port B", rd_b_data, exp);
                end
                OP_CPSR: check(req, "status", cur_status, exp);
                OP_SPSR: check(req, "saved status", saved_status, exp);
                default: ;
            endcase
        end

        // R10: coincident requests from svc (status 0x93); entry to irq wins
        @(negedge clk);
        idle();
        exc_req = 1; exc_mode = 5'b10010; exc_ret_addr = 32'h500;
        ret_req = 1; sw_en = 1; sw_data = 32'h0000_0010;
        @(negedge clk);
        idle();
        rd_a_idx = 4'd14;
        #2;
        check(10, "status after coincident requests", cur_status, 32'h0000_0092);
        check(10, "saved status after coincident requests", saved_status, 32'h0000_0093);
        check(10, "irq r14 after coincident requests", rd_a_data, 32'h500);

        // R4: same-cycle read and write of banked irq r13
        @(negedge clk);
        idle();
        wr_en = 1; wr_idx = 4'd13; wr_data = 32'h77;
        rd_a_idx = 4'd13; rd_b_idx = 4'd12;
        #2;
        check(4, "bypass on matching register", rd_a_data, 32'h77);
        check(4, "no bypass on other register", rd_b_data, 32'h0);
        @(negedge clk);
        idle();
        rd_a_idx = 4'd13;
        #2;
        check(4, "value held after bypass write", rd_a_data, 32'h77);

        // R1: reset mid-run
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_a_idx = 4'd1;
        #2;
        check(1, "status after reset", cur_status, 32'h0000_00D3);
        check(1, "r1 after reset", rd_a_data, 32'h0);

        done = 1;
        summary();
    end

endmodule